// File: doc/BRIEF.md
# Byte-Lane Static Memory Emulator

This block is a clocked, synthesizable stand-in for a 16-bit asynchronous static memory that has two independently controlled byte lanes. A memory controller under verification drives its address, an active-low chip select, write enable, output enable and a pair of active-low byte-lane enables. The emulator samples those pins on a fast internal clock, decodes the operating mode from all five control signals, stores and returns bytes, and shows each lane's tri-state through its own output-enable bit. The bidirectional data bus is split into `dq_in`, `dq_out` and a per-lane `dq_oe`.

A write is active only while chip select, write enable and at least one lane enable are all low. The array is updated on the cycle after that overlap ends. It uses the address, data and lane mask sampled on the last active cycle. A read that falls on the commit cycle sees the new bytes. The decoded mode and a standby flag are brought out so that a bench can follow the device's state. Storage is not cleared by reset. The word depth is set by the address-width parameter. A value of 18 gives the full 256K-word organisation; the default is kept smaller.

The interface consists of plain pins. There is no valid/ready handshake, because the device side of an asynchronous memory cannot stall its controller. The controller owns the timing, and the emulator follows it cycle by cycle.

Top module: `sram16_lane_emu`

## Requirements
- R1: With `cs_n` high, whatever the other controls, `mode` becomes 2'b00 (standby), `standby` is 1 and both `dq_oe` bits are 0.
- R2: With `cs_n` low and both `lb_n` and `ub_n` high, the mode is standby (2'b00) and `standby` is 1, even when `we_n` is low. No byte of the array changes.
- R3: With `cs_n` low, `we_n` high, `oe_n` high and at least one lane enable low, `mode` is 2'b01 (output disabled) and `dq_oe` is 2'b00.
- R4: With `cs_n` low, `we_n` high, `oe_n` low and at least one lane enable low, `mode` is 2'b10 (read). `dq_oe[0]` equals `!lb_n` and `dq_oe[1]` equals `!ub_n`. The lower lane is bits 7:0 and the upper lane is bits 15:8 of the stored word.
- R5: With `cs_n` low, `we_n` low and at least one lane enable low, `mode` is 2'b11 (write) whatever `oe_n` is. `dq_oe` is 0, and only the lanes whose enable is low are written.
- R6: A write commits on the cycle after the write overlap ends. It uses the data, address and lanes sampled on the last active cycle, so data changed during the overlap takes the last value.
- R7: A read of the address being committed in the same cycle returns the newly written bytes.
- R8: `mode` and `standby` follow the pins one clock edge after they are sampled. `dq_oe` and `dq_out` follow one edge after that.
- R9: During and right after reset, `mode` is standby, `standby` is 1, `dq_oe` is 0 and `dq_out` is 0.
- R10: A lane whose output enable is 0 drives zeros on its bits of `dq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Word address |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower lane (bits 7:0) enable, active low |
| ub_n | input | 1 | Upper lane (bits 15:8) enable, active low |
| dq_in | input | 16 | Data from controller |
| dq_out | output | 16 | Data to controller, zero on undriven lanes |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 lower, bit 1 upper |
| standby | output | 1 | Device in standby |
| mode | output | 2 | 00 standby, 01 disabled, 10 read, 11 write |

## Verification
The bench targets the corners where a plausible bug would still show correct data on simple reads. A write issued with both lane enables high must leave the array untouched; a decoder that ignored the lane enables would overwrite the word. Data that changes in the middle of a write must end up as the last value, which exposes a design that latches on the first cycle. A read placed on the commit cycle must return the fresh bytes, which exposes a missing bypass. Single-lane reads and writes check that each lane is gated and zeroed on its own, which catches swapped or merged lane enables.

// File: rtl/sram16_emu_pkg.sv
package sram16_emu_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'b00,
    MODE_OFF     = 2'b01,
    MODE_READ    = 2'b10,
    MODE_WRITE   = 2'b11
  } emu_mode_e;
endpackage

// File: rtl/sram16_pin_sampler.sv
module sram16_pin_sampler
  import sram16_emu_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [DATA_W-1:0] din,
  output logic [AW-1:0]     s_addr,
  output logic              s_cs_n,
  output logic              s_we_n,
  output logic              s_oe_n,
  output logic [LANES-1:0]  s_be_n,
  output logic [DATA_W-1:0] s_din
);
  // one register stage: pins are asynchronous to the emulator clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_addr <= '0;
      s_cs_n <= 1'b1;
      s_we_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_be_n <= '1;
      s_din  <= '0;
    end else begin
      s_addr <= addr;
      s_cs_n <= cs_n;
      s_we_n <= we_n;
      s_oe_n <= oe_n;
      s_be_n <= be_n;
      s_din  <= din;
    end
  end
endmodule

// File: rtl/sram16_mode_decode.sv
module sram16_mode_decode
  import sram16_emu_pkg::*;
(
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  output emu_mode_e        mode,
  output logic             wr_active
);
  logic any_lane;

  always_comb begin
    any_lane = ~&be_n;
    if (cs_n || !any_lane)
      mode = MODE_STANDBY;
    else if (!we_n)
      mode = MODE_WRITE;
    else if (!oe_n)
      mode = MODE_READ;
    else
      mode = MODE_OFF;
    wr_active = !cs_n && !we_n && any_lane;
  end
endmodule

// File: rtl/sram16_write_ctrl.sv
module sram16_write_ctrl
  import sram16_emu_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_active,
  input  logic [AW-1:0]     s_addr,
  input  logic [DATA_W-1:0] s_din,
  input  logic [LANES-1:0]  s_be_n,
  output logic [LANES-1:0]  lane_we,
  output logic [AW-1:0]     c_addr,
  output logic [DATA_W-1:0] c_data
);
  logic             act_q;
  logic [LANES-1:0] lane_q;

  // track the overlap; keep the last active cycle's address, data and lanes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      lane_q <= '0;
      c_addr <= '0;
      c_data <= '0;
    end else begin
      act_q <= wr_active;
      if (wr_active) begin
        lane_q <= ~s_be_n;
        c_addr <= s_addr;
        c_data <= s_din;
      end
    end
  end

  // commit on the first cycle after the overlap ends
  always_comb begin
    for (int i = 0; i < LANES; i++)
      lane_we[i] = act_q && !wr_active && lane_q[i];
  end
endmodule

// File: rtl/sram16_lane_array.sv
module sram16_lane_array
  import sram16_emu_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] wbyte;
    logic [LANE_W-1:0] rd_q;
    assign wbyte = wdata[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (lane_we[g])
        mem[waddr] <= wbyte;
      // bypass so a read in the commit cycle sees the new byte
      if (lane_we[g] && waddr == raddr)
        rd_q <= wbyte;
      else
        rd_q <= mem[raddr];
    end
    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram16_lane_emu.sv
module sram16_lane_emu
  import sram16_emu_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [1:0]    dq_oe,
  output logic          standby,
  output logic [1:0]    mode
);
  logic [AW-1:0]     s_addr, c_addr;
  logic              s_cs_n, s_we_n, s_oe_n;
  logic [LANES-1:0]  s_be_n, lane_we, oe_q;
  logic [DATA_W-1:0] s_din, c_data, rdata;
  emu_mode_e         cur_mode;
  logic              wr_active;

  sram16_pin_sampler #(.AW(AW)) u_smp (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .be_n({ub_n, lb_n}), .din(dq_in),
    .s_addr(s_addr), .s_cs_n(s_cs_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n),
    .s_be_n(s_be_n), .s_din(s_din)
  );

  sram16_mode_decode u_dec (
    .cs_n(s_cs_n), .we_n(s_we_n), .oe_n(s_oe_n), .be_n(s_be_n),
    .mode(cur_mode), .wr_active(wr_active)
  );

  sram16_write_ctrl #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_active(wr_active), .s_addr(s_addr),
    .s_din(s_din), .s_be_n(s_be_n), .lane_we(lane_we),
    .c_addr(c_addr), .c_data(c_data)
  );

  sram16_lane_array #(.AW(AW)) u_arr (
    .clk(clk), .lane_we(lane_we), .waddr(c_addr), .wdata(c_data),
    .raddr(s_addr), .rdata(rdata)
  );

  // lane drive enables, aligned with the registered read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      oe_q <= '0;
    else
      for (int i = 0; i < LANES; i++)
        oe_q[i] <= (cur_mode == MODE_READ) && !s_be_n[i];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++)
      dq_out[i*LANE_W +: LANE_W] = oe_q[i] ? rdata[i*LANE_W +: LANE_W] : '0;
  end

  assign dq_oe   = oe_q;
  assign mode    = cur_mode;
  assign standby = (cur_mode == MODE_STANDBY);
endmodule

// File: rtl/sram16_emu_chk.sv
module sram16_emu_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          cs_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          lb_n,
  input logic          ub_n,
  input logic [1:0]    dq_oe,
  input logic          standby,
  input logic [1:0]    mode
);
  // R1
  deselect_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (mode == 2'b00));

  // R2
  no_lane_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |=> standby);

  // R1
  standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (dq_oe == 2'b00));

  // R5
  write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n && (!lb_n || !ub_n)) |=> (mode == 2'b11));

  // R5
  write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> (dq_oe == 2'b00));

  // R4
  read_low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n && !lb_n) |=> ##1 dq_oe[0]);

  // R3
  disabled_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (dq_oe == 2'b00));

  logic unused_ok;
  assign unused_ok = ^addr;
endmodule

bind sram16_lane_emu sram16_emu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
  .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .dq_oe(dq_oe),
  .standby(standby), .mode(mode)
);

// File: tb/sram16_lane_emu_tb.sv
module sram16_lane_emu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int NV = 13;
  // {is_write, addr[9:0], data[15:0], lb_n, ub_n, oe_n}
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 10'd5,   16'hA1B2, 1'b0, 1'b0, 1'b1},
    {1'b1, 10'd9,   16'hC3D4, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'd5,   16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'd9,   16'h0000, 1'b0, 1'b1, 1'b0},
    {1'b1, 10'd5,   16'hEE77, 1'b1, 1'b0, 1'b1},
    {1'b0, 10'd5,   16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'd9,   16'h1155, 1'b0, 1'b1, 1'b0},
    {1'b0, 10'd9,   16'h0000, 1'b1, 1'b0, 1'b0},
    {1'b0, 10'd9,   16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'h3FF, 16'hFFFF, 1'b0, 1'b0, 1'b1},
    {1'b0, 10'h3FF, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'd0,   16'h0001, 1'b0, 1'b0, 1'b1},
    {1'b0, 10'd0,   16'h0000, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [15:0] dq_in = '0, dq_out;
  logic [1:0] dq_oe, mode;
  logic standby;
  logic [15:0] model [1 << AW];
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram16_lane_emu #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby), .mode(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic lb, input logic ub, input logic oe);
    @(negedge clk);
    addr = a; dq_in = d; cs_n = 1'b0; we_n = 1'b0; oe_n = oe; lb_n = lb; ub_n = ub;
    @(negedge clk);
    chk("R5 write mode", {30'd0, mode}, 32'd3);
    chk("R5 write floats", {30'd0, dq_oe}, 32'd0);
    @(negedge clk);
    idle();
    if (!lb) model[a][7:0]  = d[7:0];
    if (!ub) model[a][15:8] = d[15:8];
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic lb, input logic ub);
    logic [15:0] exp;
    exp = {ub ? 8'h00 : model[a][15:8], lb ? 8'h00 : model[a][7:0]};
    @(negedge clk);
    addr = a; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; lb_n = lb; ub_n = ub;
    @(negedge clk);
    chk("R8 R4 read mode", {30'd0, mode}, 32'd2);
    @(negedge clk);
    chk("R4 lane enables", {30'd0, dq_oe}, {30'd0, !ub, !lb});
    chk("R4 R10 read data", {16'd0, dq_out}, {16'd0, exp});
    idle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 mode", {30'd0, mode}, 32'd0);
    chk("R9 standby", {31'd0, standby}, 32'd1);
    chk("R9 dq_oe", {30'd0, dq_oe}, 32'd0);
    chk("R9 dq_out", {16'd0, dq_out}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 after release", {30'd0, mode}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][29])
        do_write(VEC[i][28:19], VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0]);
      else
        do_read(VEC[i][28:19], VEC[i][2], VEC[i][1]);
    end

    // R1 deselected with all other controls active
    @(negedge clk);
    addr = 10'd5; cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
    @(negedge clk);
    chk("R1 mode", {30'd0, mode}, 32'd0);
    chk("R1 standby", {31'd0, standby}, 32'd1);
    @(negedge clk);
    chk("R1 dq_oe", {30'd0, dq_oe}, 32'd0);
    idle();

    // R2 write attempt with both lanes off leaves storage intact
    @(negedge clk);
    addr = 10'd5; dq_in = 16'h0000; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk("R2 mode", {30'd0, mode}, 32'd0);
    chk("R2 standby", {31'd0, standby}, 32'd1);
    idle();
    repeat (3) @(negedge clk);
    do_read(10'd5, 1'b0, 1'b0);

    // R3 output disabled
    @(negedge clk);
    addr = 10'd5; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
    @(negedge clk);
    chk("R3 mode", {30'd0, mode}, 32'd1);
    @(negedge clk);
    chk("R3 dq_oe", {30'd0, dq_oe}, 32'd0);
    chk("R3 R10 dq_out", {16'd0, dq_out}, 32'd0);
    idle();

    // R6 data changed mid-write: last active value is stored
    @(negedge clk);
    addr = 10'd20; dq_in = 16'h1111; cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
    @(negedge clk);
    dq_in = 16'h2222;
    @(negedge clk);
    idle(); dq_in = 16'h3333;
    model[20] = 16'h2222;
    repeat (3) @(negedge clk);
    do_read(10'd20, 1'b0, 1'b0);
    chk("R6 last data kept", {16'd0, model[20]}, 32'h2222);

    // R7 read in the commit cycle sees new data
    do_write(10'd12, 16'h0000, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    addr = 10'd12; dq_in = 16'h5A5A; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk("R7 read mode", {30'd0, mode}, 32'd2);
    @(negedge clk);
    chk("R7 bypass data", {16'd0, dq_out}, 32'h5A5A);
    idle();
    model[12] = 16'h5A5A;
    repeat (2) @(negedge clk);
    do_read(10'd12, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule